// File: doc/BRIEF.md
# Scrambled PWM Grayscale Engine

This block turns sixteen 12-bit grayscale values into sixteen on/off channel enables, paced by an externally supplied grayscale clock. Every full PWM cycle lasts 4096 grayscale-clock periods, and each channel is on for exactly as many of those periods as its value. In the scrambled granularities the on-time is not one solid pulse. It is broken into many short pulses that repeat across the cycle. This raises the visible refresh rate without changing the integrated brightness.

The grayscale clock is sampled in the block's own clock domain, and the block advances one count per rising edge it detects. A latch strobe captures a new set of values. A control bit chooses whether the new values take effect at once or wait for the current cycle to finish. A loss guard counts ticks of a slow reference while no grayscale edge arrives. After a parameterised number of ticks it darkens every channel. When the grayscale clock returns, the counter restarts from zero.

Each value is split into a coarse part, `hi` (bits 11:6), and a fine part, `lo` (bits 5:0). The two-bit granularity code sets F = 0, 2, 4 or 6 for codes 00, 01, 10 and 11. With that F, a 6-bit count runs in steps of 2^F grayscale periods and repeats 2^(6−F) times per cycle. The channel is on while the count is below `hi`. At count `hi` it is also on in the first `lo` of the 64 single-period slots the cycle offers at that count.

Top module: `spwm_engine`

## Requirements
- R1: The PWM count advances once per detected rising edge of `gclk_i`. A full cycle is 4096 such periods in every granularity. `cycle_done_o` is high for one clock, together with the output for the last count of the cycle.
- R2: Over any full cycle, in any granularity, channel i is on for exactly v_i grayscale periods, where v_i is its 12-bit value.
- R3: Granularity 00 (single-period steps, 64 repeats): over the first 64 periods of a cycle, a channel is on for hi + (1 if lo ≠ 0, else 0) periods.
- R4: Granularity 01 (steps of 4 periods, 16 repeats): over the first 256 periods, a channel is on for 4·hi + min(lo, 4) periods.
- R5: Granularity 10 (steps of 16 periods, 4 repeats): over the first 1024 periods, a channel is on for 16·hi + min(lo, 16) periods.
- R6: Granularity 11 (direct): a channel is on during the first v periods of each cycle, so it is on for min(v, 64) of the first 64 periods.
- R7: With `apply_now_i` = 0, values captured by `latch_i` do not affect the outputs until the first count of the next cycle.
- R8: With `apply_now_i` = 1, captured values drive the outputs from the next grayscale period after the strobe.
- R9: Channel outputs change only at a detected grayscale edge or on a loss shutoff. Because of this, output from new data appears no earlier than the edge after the one that captured it.
- R10: With `guard_off_i` = 0, once TICK_LIMIT ticks of `ref_tick_i` arrive with no grayscale edge between them, all channel outputs go low within three clocks and stay low until the grayscale clock returns.
- R11: With `guard_off_i` = 1, missing grayscale edges never force the outputs low.
- R12: The first grayscale edge after a shutoff resets the count to zero and keeps outputs low. Normal output resumes on the next edge, starting from count 0.
- R13: During and after reset, all channel outputs and `cycle_done_o` are low and all stored values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run at least twice as fast as the grayscale clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk_i | input | 1 | Grayscale clock, asynchronous to `clk` |
| ref_tick_i | input | 1 | One-clock pulse from the slow time reference used by the loss guard |
| latch_i | input | 1 | One-clock strobe that captures `gray_words_i` |
| gray_words_i | input | CHANNELS*12 | Grayscale values, channel i in bits [12i+11:12i] |
| grain_i | input | 2 | Scrambling granularity code (00, 01, 10, 11) |
| apply_now_i | input | 1 | 1: captured values apply at once; 0: they wait for the cycle end |
| guard_off_i | input | 1 | 1 disables the grayscale-loss shutoff |
| chan_en_o | output | CHANNELS | Channel on/off enables |
| cycle_done_o | output | 1 | One-clock pulse marking the last count of a PWM cycle |

## Verification
Each granularity is driven with sixteen values at once. These include 0, 4095 and spread values whose coarse and fine parts vary, and whose fine parts fall both below and above the step width. Whole-cycle on-times show that the total is kept in every granularity. The first-sub-period counts separate the four granularities from each other and show how the fine part is spread. Mid-cycle strobes with each `apply_now_i` setting separate deferred from immediate update. A stalled grayscale clock with the guard disabled, then enabled, and then restarted checks the shutoff threshold and the counter restart.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Scrambling granularity: how many grayscale periods one step of the
    // 6-bit sub-period count lasts (1, 4, 16, or direct 12-bit counting).
    typedef enum logic [1:0] {
        GRAIN_1    = 2'b00,
        GRAIN_4    = 2'b01,
        GRAIN_16   = 2'b10,
        GRAIN_FLAT = 2'b11
    } grain_e;

    // Number of low count bits that form the fine position within one step.
    function automatic int unsigned fine_bits(grain_e g, int unsigned sub_bits);
        int unsigned unit;
        unit = sub_bits / 3;
        case (g)
            GRAIN_1:  fine_bits = 0;
            GRAIN_4:  fine_bits = unit;
            GRAIN_16: fine_bits = 2 * unit;
            default:  fine_bits = sub_bits;
        endcase
    endfunction

endpackage

// File: rtl/spwm_gclk_sync.sv
module spwm_gclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gclk_raw_i,
    output logic step_o
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], gclk_raw_i};
        step_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/spwm_loss_guard.sv
module spwm_loss_guard #(
    parameter int unsigned TICK_LIMIT = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic tick_i,
    input  logic guard_off_i,
    output logic lost_o
);
    localparam int unsigned    CW      = $clog2(TICK_LIMIT + 1);
    localparam logic [CW-1:0]  LIMIT_C = CW'(TICK_LIMIT);

    typedef struct packed {
        logic [CW-1:0] ticks;
        logic          lost;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.ticks = '0;
            st_d.lost  = 1'b0;
        end else begin
            if (tick_i && (st_q.ticks != LIMIT_C))
                st_d.ticks = st_q.ticks + CW'(1);
            if (!guard_off_i && (st_q.ticks == LIMIT_C))
                st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o = st_q.lost;
endmodule

// File: rtl/spwm_slot_cmp.sv
module spwm_slot_cmp #(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned SUB_BITS = 6,
    localparam int unsigned VAL_W   = 2 * SUB_BITS
) (
    input  logic [VAL_W-1:0]          cnt_i,
    input  logic [1:0]                grain_i,
    input  logic [CHANNELS*VAL_W-1:0] words_i,
    output logic [CHANNELS-1:0]       on_o
);
    import spwm_pkg::*;

    localparam logic [VAL_W-1:0] SUB_MASK = VAL_W'((1 << SUB_BITS) - 1);

    int unsigned      fbits;
    logic [VAL_W-1:0] pos;      // position of the 6-bit count inside its sub-period
    logic [VAL_W-1:0] slot;     // which of the 64 single-period slots this is
    logic [VAL_W-1:0] low_mask;

    // Shared decode: one shifter serves every channel.
    always_comb begin
        fbits    = fine_bits(grain_e'(grain_i), SUB_BITS);
        low_mask = (VAL_W'(1) << fbits) - VAL_W'(1);
        pos      = (cnt_i >> fbits) & SUB_MASK;
        slot     = ((cnt_i >> (fbits + SUB_BITS)) << fbits) | (cnt_i & low_mask);
    end

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic [VAL_W-1:0] coarse, fine;
        assign coarse   = VAL_W'(words_i[ch*VAL_W+SUB_BITS +: SUB_BITS]);
        assign fine     = VAL_W'(words_i[ch*VAL_W +: SUB_BITS]);
        assign on_o[ch] = (pos < coarse) || ((pos == coarse) && (slot < fine));
    end
endmodule

// File: rtl/spwm_engine.sv
module spwm_engine #(
    parameter int unsigned CHANNELS    = 16,
    parameter int unsigned SUB_BITS    = 6,   // must be a multiple of 3
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TICK_LIMIT  = 1_000_000,
    localparam int unsigned VAL_W      = 2 * SUB_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      gclk_i,
    input  logic                      ref_tick_i,
    input  logic                      latch_i,
    input  logic [CHANNELS*VAL_W-1:0] gray_words_i,
    input  logic [1:0]                grain_i,
    input  logic                      apply_now_i,
    input  logic                      guard_off_i,
    output logic [CHANNELS-1:0]       chan_en_o,
    output logic                      cycle_done_o
);
    localparam logic [VAL_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [VAL_W-1:0]          cnt;
        logic [CHANNELS-1:0]       chan;
        logic [CHANNELS*VAL_W-1:0] active;
        logic [CHANNELS*VAL_W-1:0] pend;
        logic                      pend_vld;
        logic                      done;
    } eng_st_t;

    eng_st_t             st_d, st_q;
    logic                gstep;
    logic                lost;
    logic [CHANNELS-1:0] cmp_on;

    spwm_gclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .gclk_raw_i (gclk_i),
        .step_o     (gstep)
    );

    spwm_loss_guard #(.TICK_LIMIT(TICK_LIMIT)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (gstep),
        .tick_i      (ref_tick_i),
        .guard_off_i (guard_off_i),
        .lost_o      (lost)
    );

    spwm_slot_cmp #(.CHANNELS(CHANNELS), .SUB_BITS(SUB_BITS)) u_cmp (
        .cnt_i   (st_q.cnt),
        .grain_i (grain_i),
        .words_i (st_q.active),
        .on_o    (cmp_on)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (lost) begin
            // Dark while the grayscale clock is missing; its return restarts the count.
            st_d.chan = '0;
            if (gstep) st_d.cnt = '0;
        end else if (gstep) begin
            st_d.chan = cmp_on;
            st_d.cnt  = st_q.cnt + VAL_W'(1);
            if (st_q.cnt == CNT_MAX) begin
                st_d.done = 1'b1;
                if (st_q.pend_vld) begin
                    st_d.active   = st_q.pend;
                    st_d.pend_vld = 1'b0;
                end
            end
        end

        if (latch_i) begin
            if (apply_now_i) begin
                st_d.active   = gray_words_i;
                st_d.pend_vld = 1'b0;
            end else begin
                st_d.pend     = gray_words_i;
                st_d.pend_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_en_o    = st_q.chan;
    assign cycle_done_o = st_q.done;
endmodule

// File: rtl/spwm_engine_chk.sv
module spwm_engine_chk #(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned VAL_W    = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      step,
    input logic                      lost,
    input logic                      apply_now,
    input logic                      done,
    input logic [CHANNELS-1:0]       chan,
    input logic [VAL_W-1:0]          cnt,
    input logic [CHANNELS*VAL_W-1:0] active
);
    // R1: the done pulse coincides with the wrap to count zero
    a_r1_done_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == '0));

    // R1: the done flag never lasts two clocks
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: every live edge advances the count by one, modulo the cycle
    a_r1_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !lost) |=> (cnt == VAL_W'($past(cnt) + VAL_W'(1))));

    // R9: outputs move only on an edge, or fall to zero on shutoff
    a_r9_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(chan) || (chan == '0)));

    // R7: in deferred mode the applied data changes only on an edge
    a_r7_defer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_now && !step) |=> $stable(active));

    // R10: a shutoff darkens every channel
    a_r10_dark: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (chan == '0));

    // R12: the returning edge restarts the count
    a_r12_resume_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && lost) |=> (cnt == '0));
endmodule

bind spwm_engine spwm_engine_chk #(
    .CHANNELS (CHANNELS),
    .VAL_W    (VAL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (gstep),
    .lost      (lost),
    .apply_now (apply_now_i),
    .done      (cycle_done_o),
    .chan      (chan_en_o),
    .cnt       (st_q.cnt),
    .active    (st_q.active)
);

// File: tb/spwm_engine_test.sv
module spwm_engine_test;
    localparam int CH    = 16;
    localparam int VW    = 12;
    localparam int LIMIT = 8;
    localparam int CYC   = 4096;

    // Stimulus table: {granularity code, base for the spread channel values}
    localparam logic [13:0] ROWS [5] = '{
        {2'd0, 12'd37}, {2'd1, 12'd1000}, {2'd2, 12'd2049},
        {2'd3, 12'd5},  {2'd0, 12'd4000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gclk = 1'b0;
    logic             gclk_run = 1'b0;
    logic             ref_tick = 1'b0;
    logic             latch = 1'b0;
    logic [CH*VW-1:0] words = '0;
    logic [1:0]       grain = 2'd3;
    logic             apply_now = 1'b1;
    logic             guard_off = 1'b0;
    logic [CH-1:0]    chan;
    logic             done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    always @(negedge clk) gclk <= gclk_run ? ~gclk : 1'b0;

    spwm_engine #(.CHANNELS(CH), .TICK_LIMIT(LIMIT)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .gclk_i       (gclk),
        .ref_tick_i   (ref_tick),
        .latch_i      (latch),
        .gray_words_i (words),
        .grain_i      (grain),
        .apply_now_i  (apply_now),
        .guard_off_i  (guard_off),
        .chan_en_o    (chan),
        .cycle_done_o (done)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic int chval(int base, int i);
        if (i == 0) return 0;
        if (i == CH - 1) return CYC - 1;
        return (base + i * 263) % CYC;
    endfunction

    function automatic int win_len(int mode);
        return (mode == 3) ? 64 : (64 << (2 * mode));
    endfunction

    function automatic int win_exp(int mode, int v);
        int hi, lo, f;
        if (mode == 3) return (v < 64) ? v : 64;
        hi = v / 64;
        lo = v % 64;
        f  = 1 << (2 * mode);
        return hi * f + ((lo < f) ? lo : f);
    endfunction

    task automatic strobe;
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
    endtask

    task automatic wait_done;
        do @(negedge clk); while (!done);
    endtask

    task automatic pulse_ticks(int n);
        for (int t = 0; t < n; t++) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int on_cnt;
        int vals [CH];

        // R13: reset state
        gclk_run = 1'b1;
        repeat (5) @(negedge clk);
        check("R13 outputs in reset", int'(chan), 0);
        check("R13 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check("R13 stored values zero after reset", int'(chan), 0);

        // Table of granularity rows
        for (int r = 0; r < 5; r++) begin
            int mode, tot [CH], win [CH], dones;
            mode = int'(ROWS[r][13:12]);
            grain = ROWS[r][13:12];
            apply_now = 1'b1;
            for (int i = 0; i < CH; i++) begin
                vals[i] = chval(int'(ROWS[r][11:0]), i);
                words[i*VW +: VW] = VW'(vals[i]);
                tot[i] = 0;
                win[i] = 0;
            end
            strobe();
            wait_done();
            @(negedge clk);
            dones = 0;
            for (int k = 0; k < 2 * CYC; k++) begin
                @(negedge clk);
                if (done) dones++;
                if (k == 2 * CYC - 2) check("R1 done at last count", int'(done), 1);
                for (int i = 0; i < CH; i++) begin
                    if (chan[i]) begin
                        tot[i]++;
                        if (k < 2 * win_len(mode)) win[i]++;
                    end
                end
            end
            check("R1 one done per cycle", dones, 1);
            for (int i = 0; i < CH; i++) begin
                check("R2 cycle on-time", tot[i], 2 * vals[i]);
                case (mode)
                    0: check("R3 first sub-period", win[i], 2 * win_exp(mode, vals[i]));
                    1: check("R4 first sub-period", win[i], 2 * win_exp(mode, vals[i]));
                    2: check("R5 first sub-period", win[i], 2 * win_exp(mode, vals[i]));
                    default: check("R6 first 64 periods", win[i], 2 * win_exp(mode, vals[i]));
                endcase
            end
        end

        // R7: deferred update waits for the cycle end
        grain = 2'd3;
        apply_now = 1'b1;
        words = '0;
        words[0 +: VW] = VW'(100);
        strobe();
        wait_done();
        @(negedge clk);
        repeat (2000) @(negedge clk);
        apply_now = 1'b0;
        words[0 +: VW] = VW'(3000);
        strobe();
        on_cnt = 0;
        do begin
            @(negedge clk);
            if (chan[0]) on_cnt++;
        end while (!done);
        check("R7 rest of cycle keeps old value", on_cnt, 0);
        @(negedge clk);
        on_cnt = 0;
        for (int k = 0; k < 2 * CYC; k++) begin
            @(negedge clk);
            if (chan[0]) on_cnt++;
        end
        check("R7 next cycle uses new value", on_cnt, 6000);

        // R8 / R9: immediate update, visible one period later
        apply_now = 1'b1;
        repeat (2000) @(negedge clk);
        check("R8 precondition on under old value", int'(chan[0]), 1);
        words[0 +: VW] = VW'(500);
        strobe();
        check("R9 no change on the capturing edge", int'(chan[0]), 1);
        repeat (4) @(negedge clk);
        check("R8 new value applied at once", int'(chan[0]), 0);

        // R10 / R11 / R12: grayscale clock loss
        for (int i = 0; i < CH; i++) words[i*VW +: VW] = VW'((i == 0) ? 64 : 4095);
        strobe();
        wait_done();
        @(negedge clk);
        repeat (1000) @(negedge clk);
        gclk_run = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 outputs before stall test", int'(chan), 16'hFFFE);
        guard_off = 1'b1;
        pulse_ticks(20);
        repeat (4) @(negedge clk);
        check("R11 guard disabled keeps outputs", int'(chan), 16'hFFFE);
        gclk_run = 1'b1;
        repeat (20) @(negedge clk);
        gclk_run = 1'b0;
        repeat (6) @(negedge clk);
        guard_off = 1'b0;
        pulse_ticks(LIMIT - 1);
        repeat (4) @(negedge clk);
        check("R10 one tick short of limit", int'(chan), 16'hFFFE);
        pulse_ticks(1);
        repeat (4) @(negedge clk);
        check("R10 shutoff at limit", int'(chan), 0);
        repeat (10) @(negedge clk);
        check("R10 stays dark", int'(chan), 0);
        gclk_run = 1'b1;
        on_cnt = 0;
        do begin
            @(negedge clk);
            if (chan[0]) on_cnt++;
        end while (!done);
        check("R12 restart from count zero", on_cnt, 128);

        summary();
    end
endmodule